// File: doc/BRIEF.md
# Power Button Event Controller

This block takes the raw, active-low power button of a platform and turns each press into exactly one power-management request. A filter first removes contact bounce. Each clean press is then routed according to the present system state, which an external power sequencer supplies. In the working state the press becomes a control-interrupt or management-interrupt request, chosen by a configuration bit. In any sleep state it becomes a wake request. In the mechanical-off state it is dropped.

A second path watches for a long hold. A press held without a break while the system is working raises a single forced soft-off request. That request depends on no other subsystem. A separate sequencer input marks when the stretch timer on the deep-sleep signal is running. While that timer runs, wake requests and the long-hold timer are both suppressed. When the stretch ends and the button is still held, the system is woken. The filtered button level is available as a status bit.

All intervals come from one tick prescaler. The production defaults give a 1 ms tick at 125 MHz, a 16 ms filter and a 4 s hold.

Top module: `pwr_button_events`

## Requirements
- R1: The button counts as pressed or released only after the synchronised input has differed from the filtered level for DEB_TICKS consecutive ticks. A pulse shorter than (DEB_TICKS-1) ticks changes neither `btn_lvl` nor any request output.
- R2: A press with `sys_state` = 0 (working) and `sci_en` = 1 raises one `sci_pulse` and no `smi_pulse`.
- R3: A press with `sys_state` = 0 and `sci_en` = 0 raises one `smi_pulse` and no `sci_pulse`.
- R4: A press with `sys_state` from 1 to 5 (sleep states S1..S5) raises one `wake_pulse` and no interrupt request.
- R5: A press with `sys_state` = 7 (mechanical off) raises no request of any kind.
- R6: A press held for OVR_TICKS ticks after filtering, while `sys_state` = 0, raises one `ovr_pulse` per hold. A release before that clears the timer, so no override follows.
- R7: The hold timer runs only while `sys_state` = 0. A press held through a sleep state first wakes the system, and the hold is timed from the moment the state returns to 0.
- R8: While `stretch_en` and `stretch_busy` are both 1, a press raises no wake and the hold timer stays cleared. When that condition ends with the button still pressed in a sleep state, one `wake_pulse` follows. With `stretch_en` = 0, `stretch_busy` has no effect.
- R9: `btn_lvl` is 1 while the filtered button is pressed and 0 while it is released, in every system state.
- R10: Every request output is a one-cycle pulse. Each press gives at most one interrupt or wake request, however long the button is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_n | input | 1 | Raw power button, low when pressed, asynchronous |
| sys_state | input | 3 | Present system state: 0 working, 1..5 sleep S1..S5, 7 mechanical off |
| sci_en | input | 1 | 1 routes working-state presses to `sci_pulse`, 0 routes them to `smi_pulse` |
| stretch_en | input | 1 | Enables the sleep-stretch gating |
| stretch_busy | input | 1 | Deep-sleep signal stretch timer is running |
| btn_lvl | output | 1 | Filtered button level, 1 = pressed |
| sci_pulse | output | 1 | Control-interrupt request |
| smi_pulse | output | 1 | Management-interrupt request |
| wake_pulse | output | 1 | Wake request towards the working state |
| ovr_pulse | output | 1 | Forced soft-off request |

## Verification
The bench builds the block with TICK_DIV = 4, DEB_TICKS = 16 and OVR_TICKS = 64. This gives a filter of about 64 clocks and a hold of about 256 clocks, instead of millions of cycles. At these sizes, glitch rejection, long holds, holds carried through a wake, and holds through a whole stretch window can all be run many times within the cycle budget. A small sequencer model in the bench moves the state to working after each wake, so the hold-after-wake behaviour can be reached. Random presses over all states and both routing settings are added to the directed cases.

// File: rtl/pbe_pkg.sv
package pbe_pkg;

    typedef enum logic [2:0] {
        SYS_S0 = 3'd0,
        SYS_S1 = 3'd1,
        SYS_S2 = 3'd2,
        SYS_S3 = 3'd3,
        SYS_S4 = 3'd4,
        SYS_S5 = 3'd5,
        SYS_RSV = 3'd6,
        SYS_G3 = 3'd7
    } sys_state_e;

    // requests produced by the router for one cycle
    typedef struct packed {
        logic sci;
        logic smi;
        logic wake;
    } evt_req_t;

    // filtered button view shared by router and hold timer
    typedef struct packed {
        logic lvl;
        logic press;
    } btn_view_t;

    function automatic logic is_sleeping(sys_state_e s);
        return (s == SYS_S1) || (s == SYS_S2) || (s == SYS_S3) ||
               (s == SYS_S4) || (s == SYS_S5);
    endfunction

    function automatic logic is_working(sys_state_e s);
        return s == SYS_S0;
    endfunction

endpackage

// File: rtl/pbe_tick_gen.sv
module pbe_tick_gen #(
    parameter int TICK_DIV = 125000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int W = $clog2(TICK_DIV);
            localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);
            logic [W-1:0] cnt;
            logic         tick_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt    <= '0;
                    tick_q <= 1'b0;
                end else begin
                    tick_q <= (cnt == LAST);
                    if (cnt == LAST) cnt <= '0;
                    else             cnt <= cnt + 1'b1;
                end
            end
            assign tick = tick_q;
        end
    endgenerate
endmodule

// File: rtl/pbe_debounce.sv
module pbe_debounce
    import pbe_pkg::*;
#(
    parameter int DEB_TICKS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      btn_n,
    output btn_view_t view
);
    localparam int W = $clog2(DEB_TICKS + 1);
    localparam logic [W-1:0] LAST = W'(DEB_TICKS - 1);

    logic [1:0]   sync_n;
    logic         lvl_q;
    logic         press_q;
    logic [W-1:0] cnt;
    logic         sample;

    assign sample = ~sync_n[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_n  <= 2'b11;
            lvl_q   <= 1'b0;
            press_q <= 1'b0;
            cnt     <= '0;
        end else begin
            sync_n  <= {sync_n[0], btn_n};
            press_q <= 1'b0;
            if (sample == lvl_q) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == LAST) begin
                    cnt     <= '0;
                    lvl_q   <= sample;
                    press_q <= sample;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign view.lvl   = lvl_q;
    assign view.press = press_q;
endmodule

// File: rtl/pbe_hold_timer.sv
module pbe_hold_timer #(
    parameter int OVR_TICKS = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic lvl,
    input  logic armed,
    output logic ovr
);
    localparam int W = $clog2(OVR_TICKS + 1);
    localparam logic [W-1:0] LAST = W'(OVR_TICKS - 1);

    logic [W-1:0] cnt;
    logic         fired;
    logic         ovr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            fired <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            ovr_q <= 1'b0;
            if (!armed) begin
                cnt <= '0;
            end else if (tick && !fired) begin
                if (cnt == LAST) begin
                    cnt   <= '0;
                    fired <= 1'b1;
                    ovr_q <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            if (!lvl) fired <= 1'b0;
        end
    end

    assign ovr = ovr_q;
endmodule

// File: rtl/pbe_router.sv
module pbe_router
    import pbe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  btn_view_t  view,
    input  sys_state_e state,
    input  logic       sci_en,
    input  logic       gate,
    output evt_req_t   req
);
    logic     gate_q;
    evt_req_t req_q;
    logic     gate_end;

    assign gate_end = gate_q && !gate;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            req_q  <= '0;
        end else begin
            gate_q      <= gate;
            req_q.sci   <= view.press && is_working(state) && sci_en;
            req_q.smi   <= view.press && is_working(state) && !sci_en;
            req_q.wake  <= is_sleeping(state) && !gate &&
                           (view.press || (gate_end && view.lvl));
        end
    end

    assign req = req_q;
endmodule

// File: rtl/pwr_button_events.sv
module pwr_button_events
    import pbe_pkg::*;
#(
    parameter int TICK_DIV  = 125000,
    parameter int DEB_TICKS = 16,
    parameter int OVR_TICKS = 4000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_n,
    input  logic [2:0] sys_state,
    input  logic       sci_en,
    input  logic       stretch_en,
    input  logic       stretch_busy,
    output logic       btn_lvl,
    output logic       sci_pulse,
    output logic       smi_pulse,
    output logic       wake_pulse,
    output logic       ovr_pulse
);
    logic       tick;
    btn_view_t  view;
    evt_req_t   req;
    sys_state_e state;
    logic       gate;
    logic       armed;

    assign state = sys_state_e'(sys_state);
    assign gate  = stretch_en && stretch_busy;
    assign armed = view.lvl && is_working(state) && !gate;

    pbe_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk (clk), .rst (rst), .tick (tick)
    );

    pbe_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
        .clk (clk), .rst (rst), .tick (tick), .btn_n (btn_n), .view (view)
    );

    pbe_router u_route (
        .clk (clk), .rst (rst), .view (view), .state (state),
        .sci_en (sci_en), .gate (gate), .req (req)
    );

    pbe_hold_timer #(.OVR_TICKS(OVR_TICKS)) u_hold (
        .clk (clk), .rst (rst), .tick (tick), .lvl (view.lvl),
        .armed (armed), .ovr (ovr_pulse)
    );

    assign btn_lvl    = view.lvl;
    assign sci_pulse  = req.sci;
    assign smi_pulse  = req.smi;
    assign wake_pulse = req.wake;
endmodule

// File: rtl/pwr_button_events_chk.sv
module pwr_button_events_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] sys_state,
    input logic       sci_en,
    input logic       stretch_en,
    input logic       stretch_busy,
    input logic       btn_lvl,
    input logic       sci_pulse,
    input logic       smi_pulse,
    input logic       wake_pulse,
    input logic       ovr_pulse
);
    a_r2_sci_needs_s0_and_en: assert property (@(posedge clk) disable iff (rst)
        sci_pulse |-> ($past(sys_state) == 3'd0 && $past(sci_en)));

    a_r3_smi_needs_s0_not_en: assert property (@(posedge clk) disable iff (rst)
        smi_pulse |-> ($past(sys_state) == 3'd0 && !$past(sci_en)));

    a_r4_wake_only_sleeping: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> ($past(sys_state) >= 3'd1 && $past(sys_state) <= 3'd5));

    a_r5_g3_silent: assert property (@(posedge clk) disable iff (rst)
        (sci_pulse || smi_pulse || wake_pulse) |-> $past(sys_state) != 3'd7);

    a_r6_ovr_while_pressed: assert property (@(posedge clk) disable iff (rst)
        ovr_pulse |-> $past(btn_lvl));

    a_r7_ovr_only_s0: assert property (@(posedge clk) disable iff (rst)
        ovr_pulse |-> $past(sys_state) == 3'd0);

    a_r8_gate_blocks: assert property (@(posedge clk) disable iff (rst)
        $past(stretch_en && stretch_busy) |-> !(wake_pulse || ovr_pulse));

    a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (sci_pulse || smi_pulse || wake_pulse) |=> !(sci_pulse || smi_pulse || wake_pulse));

    a_r10_ovr_one_cycle: assert property (@(posedge clk) disable iff (rst)
        ovr_pulse |=> !ovr_pulse);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({sci_pulse, smi_pulse, wake_pulse}) <= 1);
endmodule

bind pwr_button_events pwr_button_events_chk u_chk (
    .clk (clk), .rst (rst), .sys_state (sys_state), .sci_en (sci_en),
    .stretch_en (stretch_en), .stretch_busy (stretch_busy),
    .btn_lvl (btn_lvl), .sci_pulse (sci_pulse), .smi_pulse (smi_pulse),
    .wake_pulse (wake_pulse), .ovr_pulse (ovr_pulse)
);

// File: tb/pwr_button_events_bench.sv
`timescale 1ns/1ps
module pwr_button_events_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn_n = 1'b1;
    logic [2:0] st = 3'd0;
    logic       sci_en = 1'b0;
    logic       s_en = 1'b0;
    logic       s_busy = 1'b0;
    logic       follow = 1'b0;
    logic       btn_lvl, sci_p, smi_p, wake_p, ovr_p;

    int n_sci, n_smi, n_wake, n_ovr;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwr_button_events #(.TICK_DIV(4), .DEB_TICKS(16), .OVR_TICKS(64)) u_pwr_button_events (
        .clk (clk), .rst (rst), .btn_n (btn_n), .sys_state (st),
        .sci_en (sci_en), .stretch_en (s_en), .stretch_busy (s_busy),
        .btn_lvl (btn_lvl), .sci_pulse (sci_p), .smi_pulse (smi_p),
        .wake_pulse (wake_p), .ovr_pulse (ovr_p)
    );

    // pulse counters and sequencer model, away from the active edge
    always @(negedge clk) begin
        if (sci_p)  n_sci++;
        if (smi_p)  n_smi++;
        if (wake_p) n_wake++;
        if (ovr_p)  n_ovr++;
        if (follow && wake_p) st = 3'd0;
    end

    function automatic int exp_sci(logic [2:0] s, logic en);
        return (s == 3'd0 && en) ? 1 : 0;
    endfunction
    function automatic int exp_smi(logic [2:0] s, logic en);
        return (s == 3'd0 && !en) ? 1 : 0;
    endfunction
    function automatic int exp_wake(logic [2:0] s);
        return (s >= 3'd1 && s <= 3'd5) ? 1 : 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr();
        n_sci = 0; n_smi = 0; n_wake = 0; n_ovr = 0;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hold(int n);
        btn_n = 1'b0;
        wait_n(n);
    endtask

    task automatic release_btn();
        btn_n = 1'b1;
        wait_n(150);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        clr();
        wait_n(5);
        rst = 1'b0;
        wait_n(2);
        chk("R9 reset lvl", int'(btn_lvl), 0);
        chk("R10 reset pulses", int'(sci_p | smi_p | wake_p | ovr_p), 0);

        // R1: short glitch rejected
        st = 3'd0; sci_en = 1'b1; clr();
        hold(40); chk("R1 glitch lvl", int'(btn_lvl), 0);
        release_btn();
        chk("R1 glitch sci", n_sci, 0);

        // R2 / R9 / R10: one sci per press, long press, no override when short
        clr(); hold(200); chk("R9 lvl pressed", int'(btn_lvl), 1);
        release_btn();
        chk("R9 lvl released", int'(btn_lvl), 0);
        chk("R2 sci count", n_sci, 1);
        chk("R2 no smi", n_smi, 0);
        chk("R6 short hold no ovr", n_ovr, 0);

        // R3
        sci_en = 1'b0; clr(); hold(120); release_btn();
        chk("R3 smi count", n_smi, 1);
        chk("R3 no sci", n_sci, 0);

        // R6 / R10: long hold in S0
        clr(); hold(700);
        chk("R6 ovr count", n_ovr, 1);
        chk("R10 one smi on long hold", n_smi, 1);
        release_btn();
        clr(); hold(450); release_btn();
        chk("R6 rearm after release", n_ovr, 1);

        // R5: G3
        st = 3'd7; clr(); hold(500);
        chk("R9 lvl in G3", int'(btn_lvl), 1);
        release_btn();
        chk("R5 g3 no action", n_sci + n_smi + n_wake + n_ovr, 0);

        // R4 / R7: held through suspend, sequencer returns to S0
        st = 3'd3; follow = 1'b1; clr(); hold(500);
        chk("R7 wake count", n_wake, 1);
        chk("R7 state back to S0", int'(st), 0);
        chk("R7 ovr after wake", n_ovr, 1);
        chk("R4 no sci on wake", n_sci + n_smi, 0);
        release_btn();

        // R7: no timing while asleep without sequencer follow
        follow = 1'b0; st = 3'd4; clr(); hold(600); release_btn();
        chk("R7 no ovr in sleep", n_ovr, 0);
        chk("R4 wake in S4", n_wake, 1);

        // R8: stretch gate
        st = 3'd5; s_en = 1'b1; s_busy = 1'b1; follow = 1'b1; clr();
        hold(400);
        chk("R8 no wake during stretch", n_wake, 0);
        chk("R8 no ovr during stretch", n_ovr, 0);
        s_busy = 1'b0; wait_n(10);
        chk("R8 wake at stretch end", n_wake, 1);
        wait_n(320);
        chk("R8 ovr after stretch wake", n_ovr, 1);
        release_btn();

        // R8: busy ignored when not enabled
        follow = 1'b0; st = 3'd2; s_en = 1'b0; s_busy = 1'b1; clr();
        hold(120); release_btn();
        chk("R8 busy without enable", n_wake, 1);
        s_busy = 1'b0;

        // random presses over all states and routing
        for (int i = 0; i < 12; i++) begin
            logic [2:0] rs;
            logic       ren;
            int         hl;
            rs  = 3'($urandom_range(0, 6));
            if (rs == 3'd6) rs = 3'd7;
            ren = 1'($urandom_range(0, 1));
            hl  = int'($urandom_range(100, 180));
            st = rs; sci_en = ren; clr();
            hold(hl); release_btn();
            chk("R2 random sci", n_sci, exp_sci(rs, ren));
            chk("R3 random smi", n_smi, exp_smi(rs, ren));
            chk("R4 random wake", n_wake, exp_wake(rs));
        end

        finish_run();
    end
endmodule